// File: doc/BRIEF.md
# Multi-Mode Reloadable 16-bit Timer

This block is one 16-bit timer channel with a single counter core shared by four operating modes: periodic timing, event counting, a single timed pulse, and continuous pulse-width modulation. Software programs it through a small byte-wide register interface. It writes the reload value as two bytes, selects a mode and a count clock, and sets a start bit. The channel then reports every wrap of its counter as a one-cycle pulse, as a sticky flag and, depending on the mode, on a pulse output pin.

In the non-event modes the counter is clocked by one of four prescaled ticks: every cycle, every 8th cycle, every 32nd cycle, or every 32nd pulse of a slow sub-clock enable. In event mode each count is one detected edge from the selected source. The source can be an external pin, which is synchronised inside the block and has a selectable active edge, or the wrap pulse of the channel before or after this one in a ring of channels, or the wrap pulse of an unrelated timer. The ring wiring, where channel 0's predecessor is the last channel and the last channel's successor is channel 0, is made where the channels are instantiated. Event mode is the only mode that can count upwards.

Top module: `mmtimer16`

## Requirements
- R1: After reset the mode register (address 2) reads 00h, the counter (addresses 4 low, 5 high) reads 0000h, and wrap_pulse, wrap_flag and pulse_out are low.
- R2: Mode register bits 1:0 select the mode (00 periodic, 01 event, 10 one-shot, 11 PWM). Bit 2 enables the toggle output, bit 3 selects the falling pin edge, bits 5:4 select the event source (00 pin, 01 previous channel, 10 next channel, 11 auxiliary timer) and bits 7:6 select the count clock. The register reads back as written.
- R3: The reload value is written as a low byte (address 0) and a high byte (address 1). A write while stopped also loads that byte into the counter. A write while running changes the counter only at its next reload.
- R4: Writing the control register (address 3) with bit 0 set while stopped loads the counter from the reload value and starts counting. Writing bit 0 clear stops the counter, which then holds its value and ignores all ticks and events.
- R5: In periodic mode each tick decrements the counter. The tick after it reads 0 reloads it, raises wrap_pulse for one cycle and sets wrap_flag.
- R6: Count clock 00 ticks every cycle, 01 every 8th cycle, 10 every 32nd cycle and 11 on every 32nd sub_tick pulse. The first tick falls 1, 8, 32 cycles or 32 sub_tick pulses after the start.
- R7: In event mode each rising edge of the selected source counts exactly once. When the pin is the source, only the edge chosen by bit 3 counts. Sources that are not selected are ignored.
- R8: Control bit 1 set makes the event-mode counter count up. Past FFFFh it reloads and wraps.
- R9: In one-shot mode pulse_out is high from the start for reload-value ticks. The counter then stops at 0000h, the start bit clears and wrap_pulse is raised.
- R10: In PWM mode pulse_out is high while the running counter is nonzero. The counter reloads every 65536 ticks, so a reload value of 0 keeps pulse_out low.
- R11: In periodic and event modes pulse_out follows a flip-flop that toggles on every wrap when bit 2 is set, and stays low otherwise.
- R12: wrap_flag is readable as control bit 7. It stays set until the next control register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sub_tick | input | 1 | One-cycle enable from the slow sub-clock |
| ext_in | input | 1 | External event pin (asynchronous) |
| prev_wrap | input | 1 | Wrap pulse of the previous channel in the ring |
| next_wrap | input | 1 | Wrap pulse of the next channel in the ring |
| aux_wrap | input | 1 | Wrap pulse of an auxiliary timer |
| wrap_pulse | output | 1 | One-cycle pulse on each wrap |
| wrap_flag | output | 1 | Sticky wrap flag |
| pulse_out | output | 1 | Pulse output pin |

## Verification
The bench targets the exact tick on which each prescaler first fires. A divider that is off by one, or that keeps running while the timer is stopped, shows up as a counter one step early or late. It holds the external pin high for several cycles and changes the active edge. A design that counted levels instead of edges, or counted both edges, would step the counter more than once per pulse. It writes the reload value while the timer is running and expects no change before the next wrap, and it pulses unselected event sources expecting no count. It also runs a full 65536-tick PWM period and a one-shot pulse to its end, where a miscounted width or a missing self-stop is visible on pulse_out and the start bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PERIODIC = 2'b00,
    MD_EVENT    = 2'b01,
    MD_ONESHOT  = 2'b10,
    MD_PWM      = 2'b11
  } tmr_mode_e;

  localparam logic [2:0] A_RLD_LO = 3'd0;
  localparam logic [2:0] A_RLD_HI = 3'd1;
  localparam logic [2:0] A_MODE   = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_CNT_LO = 3'd4;
  localparam logic [2:0] A_CNT_HI = 3'd5;

  // true on the last count of a divide-by-d window
  function automatic logic div_point(input int unsigned c, input int unsigned d);
    return (c % d) == (d - 1);
  endfunction

  function automatic logic [15:0] step_down(input logic [15:0] c, input logic [15:0] rl);
    return (c == 16'h0000) ? rl : c - 16'd1;
  endfunction

  function automatic logic [15:0] step_up(input logic [15:0] c, input logic [15:0] rl);
    return (c == 16'hFFFF) ? rl : c + 16'd1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned FAST_DIV = 1,
  parameter int unsigned MID_DIV  = 8,
  parameter int unsigned SLOW_DIV = 32,
  parameter int unsigned SUB_DIV  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       sub_tick,
  input  logic [1:0] src,
  output logic       tick
);
  localparam int unsigned PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int unsigned SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

  logic [PW-1:0] pcnt_q;
  logic [SW-1:0] scnt_q;
  logic fast_tick, mid_tick, slow_tick, sub_div_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (!run) pcnt_q <= '0;
    else if (32'(pcnt_q) == SLOW_DIV - 1) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scnt_q <= '0;
    else if (!run) scnt_q <= '0;
    else if (sub_tick) begin
      if (32'(scnt_q) == SUB_DIV - 1) scnt_q <= '0;
      else scnt_q <= scnt_q + 1'b1;
    end
  end

  generate
    if (FAST_DIV == 1) begin : g_fast_direct
      assign fast_tick = run;
    end else begin : g_fast_div
      assign fast_tick = run && tmr_pkg::div_point(32'(pcnt_q), FAST_DIV);
    end
  endgenerate

  assign mid_tick     = run && tmr_pkg::div_point(32'(pcnt_q), MID_DIV);
  assign slow_tick    = run && tmr_pkg::div_point(32'(pcnt_q), SLOW_DIV);
  assign sub_div_tick = run && sub_tick && (32'(scnt_q) == SUB_DIV - 1);

  always_comb begin
    unique case (src)
      2'b00:   tick = fast_tick;
      2'b01:   tick = mid_tick;
      2'b10:   tick = slow_tick;
      default: tick = sub_div_tick;
    endcase
  end

  // R6: divided ticks never fire on back-to-back cycles
  a_r6_mid_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b01 && tick) |=> !tick);
  a_r6_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b10 && tick) |=> !tick);
endmodule

// File: rtl/tmr_event_sel.sv
module tmr_event_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ext_in,
  input  logic       fall_edge,
  input  logic       prev_wrap,
  input  logic       next_wrap,
  input  logic       aux_wrap,
  input  logic [1:0] sel,
  output logic       evt
);
  logic sync1_q, sync2_q, lvl_d_q;
  logic prev_d_q, next_d_q, aux_d_q;
  logic lvl, pin_edge, prev_edge, next_edge, aux_edge, raw_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0; sync2_q <= 1'b0; lvl_d_q <= 1'b0;
      prev_d_q <= 1'b0; next_d_q <= 1'b0; aux_d_q <= 1'b0;
    end else begin
      sync1_q  <= ext_in;
      sync2_q  <= sync1_q;
      lvl_d_q  <= lvl;
      prev_d_q <= prev_wrap;
      next_d_q <= next_wrap;
      aux_d_q  <= aux_wrap;
    end
  end

  assign lvl       = sync2_q ^ fall_edge;
  assign pin_edge  = lvl & ~lvl_d_q;
  assign prev_edge = prev_wrap & ~prev_d_q;
  assign next_edge = next_wrap & ~next_d_q;
  assign aux_edge  = aux_wrap & ~aux_d_q;

  always_comb begin
    unique case (sel)
      2'b00:   raw_evt = pin_edge;
      2'b01:   raw_evt = prev_edge;
      2'b10:   raw_evt = next_edge;
      default: raw_evt = aux_edge;
    endcase
  end

  assign evt = run & raw_evt;

  // R7: a pin transition yields a single-cycle event
  a_r7_pin_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> !pin_edge);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PWM_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tmr_pkg::tmr_mode_e mode,
  input  logic               run,
  input  logic               tick,
  input  logic               count_up,
  input  logic               start_load,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [7:0]         wdata,
  input  logic [CNT_W-1:0]   reload,
  output logic [CNT_W-1:0]   cnt,
  output logic               wrap_evt
);
  import tmr_pkg::*;
  localparam logic [PWM_BITS-1:0] PER_LAST = '1;

  logic [CNT_W-1:0]    cnt_q;
  logic [PWM_BITS-1:0] per_q;
  logic                adv;
  logic                wrap_c;

  assign adv = run && tick && !start_load;

  always_comb begin
    unique case (mode)
      MD_PERIODIC: wrap_c = (cnt_q == '0);
      MD_EVENT:    wrap_c = count_up ? (cnt_q == '1) : (cnt_q == '0);
      MD_ONESHOT:  wrap_c = (cnt_q <= 1);
      default:     wrap_c = (per_q == PER_LAST);
    endcase
  end

  assign wrap_evt = adv && wrap_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (start_load) begin
      cnt_q <= reload;
      per_q <= '0;
    end else if (!run) begin
      if (wr_lo) cnt_q[7:0] <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:8] <= wdata[CNT_W-9:0];
    end else if (tick) begin
      unique case (mode)
        MD_PERIODIC: cnt_q <= step_down(cnt_q, reload);
        MD_EVENT:    cnt_q <= count_up ? step_up(cnt_q, reload) : step_down(cnt_q, reload);
        MD_ONESHOT:  cnt_q <= (cnt_q <= 1) ? '0 : cnt_q - 1'b1;
        default: begin
          per_q <= per_q + 1'b1;
          if (per_q == PER_LAST) cnt_q <= reload;
          else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign cnt = cnt_q;

  // R4: a stopped counter moves only through bus loads
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_load && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R5: a wrap in a reloading mode leaves the reload value in the counter
  a_r5_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && mode != MD_ONESHOT) |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/mmtimer16.sv
module mmtimer16 #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned FAST_DIV = 1,
  parameter int unsigned MID_DIV  = 8,
  parameter int unsigned SLOW_DIV = 32,
  parameter int unsigned SUB_DIV  = 32,
  parameter int unsigned PWM_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sub_tick,
  input  logic       ext_in,
  input  logic       prev_wrap,
  input  logic       next_wrap,
  input  logic       aux_wrap,
  output logic       wrap_pulse,
  output logic       wrap_flag,
  output logic       pulse_out
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] reload_q;
  logic [7:0]       mode_q;
  logic             run_q, up_q, flag_q, irq_q, tog_q;
  logic [CNT_W-1:0] cnt;
  logic             wr_lo, wr_hi, wr_mode, wr_ctrl, start_load;
  logic             pre_tick, evt, tick, wrap_evt, os_done;
  tmr_mode_e        mode;

  assign mode       = tmr_mode_e'(mode_q[1:0]);
  assign wr_lo      = bus_wr && bus_addr == A_RLD_LO;
  assign wr_hi      = bus_wr && bus_addr == A_RLD_HI;
  assign wr_mode    = bus_wr && bus_addr == A_MODE;
  assign wr_ctrl    = bus_wr && bus_addr == A_CTRL;
  assign start_load = wr_ctrl && bus_wdata[0] && !run_q;
  assign tick       = (mode == MD_EVENT) ? evt : pre_tick;
  assign os_done    = wrap_evt && mode == MD_ONESHOT;

  tmr_prescale #(.FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV),
                 .SUB_DIV(SUB_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sub_tick(sub_tick),
    .src(mode_q[7:6]), .tick(pre_tick));

  tmr_event_sel u_evt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .ext_in(ext_in),
    .fall_edge(mode_q[3]), .prev_wrap(prev_wrap), .next_wrap(next_wrap),
    .aux_wrap(aux_wrap), .sel(mode_q[5:4]), .evt(evt));

  tmr_core #(.CNT_W(CNT_W), .PWM_BITS(PWM_BITS)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run_q), .tick(tick),
    .count_up(up_q), .start_load(start_load), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .reload(reload_q), .cnt(cnt), .wrap_evt(wrap_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0; mode_q <= '0; run_q <= 1'b0; up_q <= 1'b0;
      flag_q <= 1'b0; irq_q <= 1'b0; tog_q <= 1'b0;
    end else begin
      if (wr_lo) reload_q[7:0] <= bus_wdata;
      if (wr_hi) reload_q[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_ctrl) begin
        run_q <= bus_wdata[0];
        up_q  <= bus_wdata[1];
      end else if (os_done) begin
        run_q <= 1'b0;
      end
      irq_q <= wrap_evt;
      if (wrap_evt) flag_q <= 1'b1;
      else if (wr_ctrl) flag_q <= 1'b0;
      if (wrap_evt) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    unique case (mode)
      MD_ONESHOT: pulse_out = run_q;
      MD_PWM:     pulse_out = run_q && (cnt != '0);
      default:    pulse_out = mode_q[2] && tog_q;
    endcase
  end

  always_comb begin
    unique case (bus_addr)
      A_RLD_LO: bus_rdata = reload_q[7:0];
      A_RLD_HI: bus_rdata = 8'(reload_q[CNT_W-1:8]);
      A_MODE:   bus_rdata = mode_q;
      A_CTRL:   bus_rdata = {flag_q, 5'b0, up_q, run_q};
      A_CNT_LO: bus_rdata = cnt[7:0];
      A_CNT_HI: bus_rdata = 8'(cnt[CNT_W-1:8]);
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign wrap_pulse = irq_q;
  assign wrap_flag  = flag_q;

  // R9: the one-shot stops itself at its end
  a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (os_done && !wr_ctrl) |=> !run_q);
  // R10: a PWM counter at zero never drives the pin high
  a_r10_pwm_low_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWM && cnt == '0) |-> !pulse_out);
  // R12: the flag is set after every wrap
  a_r12_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> wrap_flag);
endmodule

// File: tb/mmtimer16_tb.sv
`timescale 1ns/100ps
module mmtimer16_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sub_tick = 1'b0, ext_in = 1'b0, prev_wrap = 1'b0, next_wrap = 1'b0, aux_wrap = 1'b0;
  logic wrap_pulse, wrap_flag, pulse_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmtimer16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_tick(sub_tick),
    .ext_in(ext_in), .prev_wrap(prev_wrap), .next_wrap(next_wrap),
    .aux_wrap(aux_wrap), .wrap_pulse(wrap_pulse), .wrap_flag(wrap_flag),
    .pulse_out(pulse_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #0.2; d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(3'd4, lo); rd(3'd5, hi);
    c = {hi, lo};
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_reload(input logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] c;
    rd(3'd2, d); chk("R1 mode reg", d, 8'h00);
    rd_cnt(c);   chk("R1 counter", c, 16'h0);
    chk("R1 outputs", {wrap_pulse, wrap_flag, pulse_out}, 3'b000);
  endtask

  task automatic t_periodic;
    logic [15:0] c; logic [7:0] d;
    wr(3'd2, 8'h04);
    rd(3'd2, d); chk("R2 mode readback", d, 8'h04);
    set_reload(16'd5);
    rd_cnt(c); chk("R3 stopped write loads counter", c, 16'd5);
    wr(3'd3, 8'h01);
    wait_n(3); rd_cnt(c); chk("R5 decrement", c, 16'd2);
    wait_n(2); rd_cnt(c); chk("R5 reaches zero", c, 16'd0);
    chk("R5 no pulse before wrap", wrap_pulse, 1'b0);
    wait_n(1); rd_cnt(c); chk("R5 reload on wrap", c, 16'd5);
    chk("R5 wrap pulse", wrap_pulse, 1'b1);
    chk("R11 toggle output", pulse_out, 1'b1);
    rd(3'd3, d); chk("R12 flag in ctrl bit7", d[7], 1'b1);
    wait_n(1); chk("R5 pulse one cycle", wrap_pulse, 1'b0);
    wr(3'd0, 8'd2);
    for (int i = 0; i < 20 && !wrap_pulse; i++) wait_n(1);
    rd_cnt(c); chk("R3 running write used at next reload", c, 16'd2);
    wr(3'd3, 8'h00);
    rd_cnt(c); chk("R4 stop edge", c, 16'd1);
    wait_n(10); rd_cnt(c); chk("R4 frozen", c, 16'd1);
    rd(3'd3, d); chk("R12 flag cleared by ctrl write", d[7], 1'b0);
  endtask

  task automatic t_prescale;
    logic [15:0] c;
    wr(3'd2, 8'h40); set_reload(16'd20); wr(3'd3, 8'h01);
    wait_n(7); rd_cnt(c); chk("R6 div8 before first tick", c, 16'd20);
    wait_n(1); rd_cnt(c); chk("R6 div8 first tick", c, 16'd19);
    wait_n(8); rd_cnt(c); chk("R6 div8 second tick", c, 16'd18);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h80); set_reload(16'd20); wr(3'd3, 8'h01);
    wait_n(31); rd_cnt(c); chk("R6 div32 before tick", c, 16'd20);
    wait_n(1); rd_cnt(c); chk("R6 div32 tick", c, 16'd19);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'hC0); set_reload(16'd10); wr(3'd3, 8'h01);
    for (int i = 0; i < 31; i++) begin sub_tick = 1'b1; wait_n(1); sub_tick = 1'b0; wait_n(1); end
    rd_cnt(c); chk("R6 sub-clock 31 pulses", c, 16'd10);
    sub_tick = 1'b1; wait_n(1); sub_tick = 1'b0; wait_n(1);
    rd_cnt(c); chk("R6 sub-clock 32nd pulse", c, 16'd9);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h00); set_reload(16'd0); wr(3'd3, 8'h01);
    wait_n(6); chk("R11 toggle disabled keeps pin low", pulse_out, 1'b0);
    wr(3'd3, 8'h00);
  endtask

  task automatic pin_pulse;
    ext_in = 1'b1; wait_n(5); ext_in = 1'b0; wait_n(5);
  endtask

  task automatic t_event;
    logic [15:0] c;
    wr(3'd2, 8'h01); set_reload(16'd2); wr(3'd3, 8'h01);
    pin_pulse(); rd_cnt(c); chk("R7 one count per pin pulse", c, 16'd1);
    pin_pulse(); rd_cnt(c); chk("R7 second pin pulse", c, 16'd0);
    wr(3'd3, 8'h01);
    pin_pulse(); rd_cnt(c); chk("R7 event wrap reload", c, 16'd2);
    chk("R12 flag after event wrap", wrap_flag, 1'b1);
    wr(3'd3, 8'h00);
    pin_pulse(); rd_cnt(c); chk("R4 stopped ignores events", c, 16'd2);
    wr(3'd2, 8'h09); set_reload(16'd5); wr(3'd3, 8'h01);
    ext_in = 1'b1; wait_n(5); rd_cnt(c); chk("R7 rising ignored in falling mode", c, 16'd5);
    ext_in = 1'b0; wait_n(5); rd_cnt(c); chk("R7 falling counted", c, 16'd4);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h11); set_reload(16'hFFFE); wr(3'd3, 8'h03);
    prev_wrap = 1'b1; wait_n(1); prev_wrap = 1'b0; wait_n(1);
    rd_cnt(c); chk("R8 up count from previous channel", c, 16'hFFFF);
    aux_wrap = 1'b1; next_wrap = 1'b1; wait_n(1); aux_wrap = 1'b0; next_wrap = 1'b0; wait_n(1);
    rd_cnt(c); chk("R7 unselected sources ignored", c, 16'hFFFF);
    prev_wrap = 1'b1; wait_n(1); prev_wrap = 1'b0;
    chk("R8 overflow pulse", wrap_pulse, 1'b1);
    wait_n(1); rd_cnt(c); chk("R8 overflow reloads", c, 16'hFFFE);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h21); set_reload(16'd3); wr(3'd3, 8'h01);
    next_wrap = 1'b1; wait_n(3); next_wrap = 1'b0; wait_n(1);
    rd_cnt(c); chk("R7 next channel held high counts once", c, 16'd2);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_oneshot;
    logic [15:0] c; logic [7:0] d;
    wr(3'd2, 8'h02); set_reload(16'd4); wr(3'd3, 8'h01);
    for (int n = 0; n < 4; n++) begin
      chk("R9 pulse high during width", pulse_out, 1'b1);
      wait_n(1);
    end
    chk("R9 pulse ends after width", pulse_out, 1'b0);
    chk("R9 end pulse", wrap_pulse, 1'b1);
    rd(3'd3, d); chk("R9 start bit cleared", d[0], 1'b0);
    rd_cnt(c); chk("R9 counter at zero", c, 16'd0);
    wait_n(3); chk("R9 no second pulse", pulse_out, 1'b0);
  endtask

  task automatic t_pwm;
    logic [15:0] c;
    wr(3'd2, 8'h03); set_reload(16'd3); wr(3'd3, 8'h01);
    for (int n = 0; n < 3; n++) begin
      chk("R10 high while nonzero", pulse_out, 1'b1);
      wait_n(1);
    end
    chk("R10 low at zero", pulse_out, 1'b0);
    wait_n(65532); chk("R10 low through period", pulse_out, 1'b0);
    wait_n(1); rd_cnt(c); chk("R10 period reload", c, 16'd3);
    chk("R10 period pulse", wrap_pulse, 1'b1);
    chk("R10 high again", pulse_out, 1'b1);
    wr(3'd3, 8'h00);
    set_reload(16'd0); wr(3'd3, 8'h01);
    wait_n(8); chk("R10 zero reload stays low", pulse_out, 1'b0);
    wr(3'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_prescale();
    t_event();
    t_oneshot();
    t_pwm();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule